// File: doc/BRIEF.md
# I2C Bus Condition Detector and Generator

This block watches the two wires of an I2C-style bus and recognises start and stop conditions. It also drives start, repeated-start and stop conditions onto the bus when software asks for them. Both lines first pass through a multi-flop synchroniser. They are then looked at only on a prescaled sampling tick. A data-line edge counts as a condition only when the clock line was high for long enough before the edge and stays high for long enough after it. The required interval is a programmable number of sampling ticks.

Both kinds of condition raise one shared event pulse. A bus-busy flag tells the two apart: it is set by a start and cleared by a stop. On the generation side, three request bits can be set. A request only arms the generator. The generator takes the pins only while the output-select input is high; otherwise the pins follow the ordinary serial path's drive enables. Both lines are open-drain, so an enable of 1 pulls the line low and 0 releases it.

Top module: `i2c_cond_unit`

## Requirements
- R1: When SDA falls while SCL is high and the setup and hold intervals are both met, `cond_irq` pulses high for exactly one clock and `bus_busy` becomes 1.
- R2: When SDA rises while SCL is high and the setup and hold intervals are both met, the same `cond_irq` output pulses for one clock and `bus_busy` becomes 0.
- R3: Setup interval: let SCL be first seen high at tick a, and the SDA edge be seen at tick a+n. The edge qualifies only if n > T, where T is the effective threshold. So n = T is rejected and n = T+1 is accepted.
- R4: Hold interval: let the SDA edge be seen at tick e. SCL must be high at every tick from e+1 through e+T+1. If SCL is seen low at tick e+T+1 the event is dropped; if it stays high until tick e+T+2 the event is raised.
- R5: The effective threshold T is `thr_sel` clamped to the range 3 to 6. Values 0 to 2 act as 3, and 7 acts as 6.
- R6: The `req_*_set` pulses set the pending bits `req_pend` (bit 0 = start, bit 1 = repeated start, bit 2 = stop). While `out_sel` is 0 the generator takes no action, and `scl_oe`/`sda_oe` equal `ser_scl_oe`/`ser_sda_oe`.
- R7: With `out_sel` = 1 the generator carries out one request at a time. Stop is served before repeated start, and repeated start before start.
- R8: A generated start pulls SDA low with SCL released, holds for T+2 ticks, then pulls SCL low. It ends with both lines pulled low, and the detector reports it as a start.
- R9: A generated stop pulls both lines low, then releases SCL, then after T+2 ticks releases SDA. The detector reports it as a stop.
- R10: A generated repeated start releases SDA while SCL is low, then releases SCL, then after T+2 ticks pulls SDA low, then after T+2 ticks pulls SCL low. The detector reports it as a start.
- R11: Each generated condition ends with a one-clock `gen_done` pulse, T+2 ticks after its last pin change. The served request bit clears at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling tick, one clock wide |
| scl_in | input | 1 | Level seen on the SCL wire |
| sda_in | input | 1 | Level seen on the SDA wire |
| thr_sel | input | SEL_W | Setup/hold threshold in ticks, before clamping |
| req_start_set | input | 1 | Sets the pending start request |
| req_rstart_set | input | 1 | Sets the pending repeated-start request |
| req_stop_set | input | 1 | Sets the pending stop request |
| out_sel | input | 1 | 1 hands the pins to the condition generator |
| ser_scl_oe | input | 1 | SCL pull-down from the normal serial path |
| ser_sda_oe | input | 1 | SDA pull-down from the normal serial path |
| scl_oe | output | 1 | SCL open-drain pull-down enable |
| sda_oe | output | 1 | SDA open-drain pull-down enable |
| cond_irq | output | 1 | One-clock pulse on a detected start or stop |
| bus_busy | output | 1 | Set by a start, cleared by a stop |
| gen_done | output | 1 | One-clock pulse when a generated condition completes |
| req_pend | output | 3 | Pending requests: {stop, repeated start, start} |

## Verification
The in-line assertions check several things on every cycle: the event pulse and done pulse last one clock, `bus_busy` changes only together with the event pulse, a candidate edge is accepted only with its setup count exceeded, the generator stays frozen while it does not own the pins, and a running operation never changes kind. The exact tick boundaries of setup and hold, the clamping of the threshold, the order in which pending requests are served, and whether each generated waveform is recognised by the detector can only be shown by the bench. The bench sweeps every threshold setting across both sides of each boundary and runs the generator in a loop-back bus model.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_START  = 2'd1,
      OP_RSTART = 2'd2,
      OP_STOP   = 2'd3
   } cond_op_e;

   // One phase of a generated waveform: pin pull-downs and end marker
   typedef struct packed {
      logic scl_oe;
      logic sda_oe;
      logic last;
   } gen_step_t;

   function automatic gen_step_t step_of(cond_op_e op, logic [1:0] idx);
      gen_step_t s;
      s = '{scl_oe: 1'b0, sda_oe: 1'b0, last: 1'b1};
      unique case (op)
         OP_START: begin
            case (idx)
               2'd0:    s = '{scl_oe: 1'b0, sda_oe: 1'b1, last: 1'b0};
               default: s = '{scl_oe: 1'b1, sda_oe: 1'b1, last: 1'b1};
            endcase
         end
         OP_STOP: begin
            case (idx)
               2'd0:    s = '{scl_oe: 1'b1, sda_oe: 1'b1, last: 1'b0};
               2'd1:    s = '{scl_oe: 1'b0, sda_oe: 1'b1, last: 1'b0};
               default: s = '{scl_oe: 1'b0, sda_oe: 1'b0, last: 1'b1};
            endcase
         end
         OP_RSTART: begin
            case (idx)
               2'd0:    s = '{scl_oe: 1'b1, sda_oe: 1'b0, last: 1'b0};
               2'd1:    s = '{scl_oe: 1'b0, sda_oe: 1'b0, last: 1'b0};
               2'd2:    s = '{scl_oe: 1'b0, sda_oe: 1'b1, last: 1'b0};
               default: s = '{scl_oe: 1'b1, sda_oe: 1'b1, last: 1'b1};
            endcase
         end
         default: s = '{scl_oe: 1'b0, sda_oe: 1'b0, last: 1'b1};
      endcase
      return s;
   endfunction

   function automatic logic [2:0] op_mask(cond_op_e op);
      logic [2:0] m;
      case (op)
         OP_START:  m = 3'b001;
         OP_RSTART: m = 3'b010;
         OP_STOP:   m = 3'b100;
         default:   m = 3'b000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
   parameter int WIDTH   = 2,
   parameter int STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("cond_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= {WIDTH{RST_VAL}};
               else        chain[gi] <= d;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= {WIDTH{RST_VAL}};
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cond_detect.sv
module cond_detect #(
   parameter int CNT_W = 4,
   parameter int SAT   = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             scl,
   input  logic             sda,
   input  logic [CNT_W-1:0] thr,
   output logic             irq,
   output logic             busy
);

   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

   logic             sda_q;
   logic [CNT_W-1:0] hi_cnt;
   logic             hold_act;
   logic             hold_start;
   logic [CNT_W-1:0] hold_cnt;
   logic             sda_edge;
   logic             setup_ok;

   assign sda_edge = tick && (sda != sda_q);
   assign setup_ok = scl && (hi_cnt > thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_q      <= 1'b1;
         hi_cnt     <= '0;
         hold_act   <= 1'b0;
         hold_start <= 1'b0;
         hold_cnt   <= '0;
         irq        <= 1'b0;
         busy       <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (tick) begin
            sda_q <= sda;
            if (!scl)                hi_cnt <= '0;
            else if (hi_cnt != SAT_V) hi_cnt <= hi_cnt + 1'b1;

            if (sda_edge) begin
               if (setup_ok) begin
                  hold_act   <= 1'b1;
                  hold_start <= ~sda;
                  hold_cnt   <= '0;
               end else begin
                  hold_act   <= 1'b0;
               end
            end else if (hold_act) begin
               if (!scl) begin
                  hold_act <= 1'b0;
               end else if (hold_cnt == thr) begin
                  hold_act <= 1'b0;
                  irq      <= 1'b1;
                  busy     <= hold_start;
               end else begin
                  hold_cnt <= hold_cnt + 1'b1;
               end
            end
         end
      end
   end

   // R1/R2: the shared event is a single-clock pulse
   a_r1_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R2: the busy flag only moves together with a reported event
   a_r2_busy_moves_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(busy) |-> irq);

   // R3: a candidate is only armed when the setup count was exceeded
   a_r3_setup_met: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_act) |-> $past(hi_cnt > thr));

   // R4: an event is only confirmed with the clock line still high
   a_r4_confirm_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(scl));

endmodule

// File: rtl/cond_gen.sv
module cond_gen
   import i2c_cond_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             out_sel,
   input  logic [CNT_W-1:0] thr,
   input  logic [2:0]       req,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             done,
   output logic [2:0]       clr
);

   cond_op_e   pick;
   cond_op_e   op;
   logic       run;
   logic [1:0] idx;
   logic [CNT_W-1:0] cnt;
   gen_step_t  drv;
   gen_step_t  first;
   gen_step_t  nxt;
   logic [CNT_W-1:0] phase_end;

   // R7: fixed service order stop > repeated start > start
   always_comb begin
      if (req[2])      pick = OP_STOP;
      else if (req[1]) pick = OP_RSTART;
      else if (req[0]) pick = OP_START;
      else             pick = OP_NONE;
   end

   assign first     = step_of(pick, 2'd0);
   assign nxt       = step_of(op, idx + 2'd1);
   assign phase_end = thr + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op   <= OP_NONE;
         run  <= 1'b0;
         idx  <= '0;
         cnt  <= '0;
         drv  <= '{scl_oe: 1'b0, sda_oe: 1'b0, last: 1'b1};
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            if (tick && out_sel && pick != OP_NONE) begin
               op  <= pick;
               idx <= '0;
               cnt <= '0;
               run <= 1'b1;
               drv <= first;
            end
         end else if (tick && out_sel) begin
            if (cnt == phase_end) begin
               cnt <= '0;
               if (drv.last) begin
                  run  <= 1'b0;
                  done <= 1'b1;
               end else begin
                  idx <= idx + 2'd1;
                  drv <= nxt;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign scl_oe = drv.scl_oe;
   assign sda_oe = drv.sda_oe;
   assign clr    = done ? op_mask(op) : 3'b000;

   // R11: completion is a single-clock pulse
   a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: without pin ownership the generator stays frozen
   a_r6_frozen_without_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !out_sel |=> $stable({run, scl_oe, sda_oe}));

   // R7: a running operation never changes kind
   a_r7_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(op));

   // R8: a generated start pulls SCL only with SDA already low
   a_r8_start_sda_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl_oe) && op == OP_START) |-> (sda_oe && $past(sda_oe)));

endmodule

// File: rtl/i2c_cond_unit.sv
module i2c_cond_unit #(
   parameter int SEL_W       = 3,
   parameter int MIN_THR     = 3,
   parameter int MAX_THR     = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic [SEL_W-1:0] thr_sel,
   input  logic             req_start_set,
   input  logic             req_rstart_set,
   input  logic             req_stop_set,
   input  logic             out_sel,
   input  logic             ser_scl_oe,
   input  logic             ser_sda_oe,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             cond_irq,
   output logic             bus_busy,
   output logic             gen_done,
   output logic [2:0]       req_pend
);

   localparam int CNT_W = $clog2(MAX_THR + 3);
   localparam int SAT   = MAX_THR + 1;

   generate
      if (MIN_THR < 1 || MIN_THR > MAX_THR) begin : g_bad_thr
         $error("i2c_cond_unit: threshold range is empty");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_cond_unit: at least two synchroniser stages required");
      end
   endgenerate

   logic [1:0]       line_s;
   logic [CNT_W-1:0] thr_eff;
   logic [2:0]       req_q;
   logic [2:0]       clr;
   logic             g_scl_oe;
   logic             g_sda_oe;

   // R5: clamp the programmed threshold
   always_comb begin
      if (int'(thr_sel) < MIN_THR)      thr_eff = CNT_W'(MIN_THR);
      else if (int'(thr_sel) > MAX_THR) thr_eff = CNT_W'(MAX_THR);
      else                              thr_eff = CNT_W'(thr_sel);
   end

   cond_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (line_s)
   );

   cond_detect #(.CNT_W(CNT_W), .SAT(SAT)) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .scl   (line_s[1]),
      .sda   (line_s[0]),
      .thr   (thr_eff),
      .irq   (cond_irq),
      .busy  (bus_busy)
   );

   // R6/R11: pending request bits, set by pulses, cleared on completion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= (req_q & ~clr) | {req_stop_set, req_rstart_set, req_start_set};
   end

   cond_gen #(.CNT_W(CNT_W)) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .out_sel (out_sel),
      .thr     (thr_eff),
      .req     (req_q & ~clr),
      .scl_oe  (g_scl_oe),
      .sda_oe  (g_sda_oe),
      .done    (gen_done),
      .clr     (clr)
   );

   assign scl_oe   = out_sel ? g_scl_oe : ser_scl_oe;
   assign sda_oe   = out_sel ? g_sda_oe : ser_sda_oe;
   assign req_pend = req_q;

endmodule

// File: tb/tb_i2c_cond_unit.sv
module tb_i2c_cond_unit;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic scl_d = 1'b1, sda_d = 1'b1;
   logic [2:0] thr_sel = 3'd3;
   logic rs_start = 1'b0, rs_rstart = 1'b0, rs_stop = 1'b0;
   logic out_sel = 1'b0, ser_scl = 1'b0, ser_sda = 1'b0;
   logic scl_oe, sda_oe, cond_irq, bus_busy, gen_done;
   logic [2:0] req_pend;
   logic scl_w, sda_w;

   int checks = 0, errors = 0;
   int irq_n = 0, done_n = 0;
   int exp_irq = 0;
   logic exp_busy = 1'b0;

   always #2 clk = ~clk;

   // Open-drain wires: released lines float high unless someone pulls
   assign scl_w = scl_d & ~scl_oe;
   assign sda_w = sda_d & ~sda_oe;

   i2c_cond_unit dut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .scl_in(scl_w), .sda_in(sda_w), .thr_sel(thr_sel),
      .req_start_set(rs_start), .req_rstart_set(rs_rstart), .req_stop_set(rs_stop),
      .out_sel(out_sel), .ser_scl_oe(ser_scl), .ser_sda_oe(ser_sda),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .cond_irq(cond_irq), .bus_busy(bus_busy),
      .gen_done(gen_done), .req_pend(req_pend)
   );

   always @(negedge clk) begin
      if (rst_n) tick <= ~tick;
      if (cond_irq) irq_n <= irq_n + 1;
      if (gen_done) done_n <= done_n + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (2 * n) @(negedge clk);
   endtask

   function automatic int clampv(input int s);
      if (s < 3) return 3;
      if (s > 6) return 6;
      return s;
   endfunction

   // Drive one SDA edge with SCL high n ticks before it and m ticks after it
   task automatic do_cond(input bit is_start, input int n, input int m);
      scl_d = 1'b0; wt(2);
      sda_d = is_start; wt(2);
      scl_d = 1'b1; wt(n);
      sda_d = ~is_start; wt(m);
      scl_d = 1'b0; wt(2);
      sda_d = 1'b1; wt(2);
      scl_d = 1'b1; wt(4);
   endtask

   task automatic expect_bus(input string req);
      chk(irq_n == exp_irq, req, irq_n, exp_irq);
      chk(bus_busy == exp_busy, req, int'(bus_busy), int'(exp_busy));
   endtask

   task automatic wait_done(input string req);
      int start;
      start = done_n;
      for (int i = 0; i < 400 && done_n == start; i++) wt(1);
      chk(done_n == start + 1, req, done_n - start, 1);
   endtask

   task automatic pulse_req(input bit s, input bit r, input bit p);
      rs_start = s; rs_rstart = r; rs_stop = p;
      @(negedge clk);
      rs_start = 1'b0; rs_rstart = 1'b0; rs_stop = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk(scl_oe == 0 && sda_oe == 0, "R6 reset pins", {scl_oe, sda_oe}, 0);
      chk(cond_irq == 0 && bus_busy == 0, "R1 reset status", {cond_irq, bus_busy}, 0);
      chk(req_pend == 0 && gen_done == 0, "R11 reset requests", {req_pend, gen_done}, 0);
      @(negedge clk);
      wt(4);

      // Sweep every threshold setting across setup and hold boundaries
      for (int sel = 0; sel < 8; sel++) begin
         int t;
         string tg;
         thr_sel = 3'(sel);
         t = clampv(sel);
         tg = (sel < 3 || sel > 6) ? "R5" : "R3";
         wt(2);
         for (int n = t; n <= t + 1; n++) begin
            do_cond(1'b1, n, t + 4);
            if (n > t) begin exp_irq++; exp_busy = 1'b1; end
            expect_bus($sformatf("%s/R1 start setup sel=%0d n=%0d", tg, sel, n));
            if (exp_busy) begin
               do_cond(1'b0, t + 4, t + 4);
               exp_irq++; exp_busy = 1'b0;
               expect_bus("R2 clean stop");
            end
         end
         for (int m = t + 1; m <= t + 2; m++) begin
            do_cond(1'b1, t + 4, m);
            if (m >= t + 2) begin exp_irq++; exp_busy = 1'b1; end
            expect_bus($sformatf("R4 start hold sel=%0d m=%0d", sel, m));
            if (exp_busy) begin
               do_cond(1'b0, t + 4, t + 4);
               exp_irq++; exp_busy = 1'b0;
            end
         end
         for (int k = 0; k < 4; k++) begin
            int n, m;
            n = (k == 0) ? t : (k == 1) ? t + 1 : t + 4;
            m = (k == 2) ? t + 1 : (k == 3) ? t + 2 : t + 4;
            do_cond(1'b1, t + 4, t + 4);
            exp_irq++; exp_busy = 1'b1;
            do_cond(1'b0, n, m);
            if (n > t && m >= t + 2) begin exp_irq++; exp_busy = 1'b0; end
            expect_bus($sformatf("R2 stop sel=%0d n=%0d m=%0d (R3/R4)", sel, n, m));
            if (exp_busy) begin
               do_cond(1'b0, t + 4, t + 4);
               exp_irq++; exp_busy = 1'b0;
            end
         end
      end

      // Generator, threshold 3 (phases of 5 ticks)
      thr_sel = 3'd3;
      wt(4);
      ser_scl = 1'b1; wt(2);
      ser_sda = 1'b1; wt(2);
      chk(scl_oe == 1 && sda_oe == 1, "R6 serial path owns pins", {scl_oe, sda_oe}, 3);
      ser_sda = 1'b0; wt(2);
      ser_scl = 1'b0; wt(4);
      chk(scl_oe == 0 && sda_oe == 0, "R6 serial release", {scl_oe, sda_oe}, 0);
      expect_bus("R6 serial traffic without condition");

      pulse_req(1'b1, 1'b0, 1'b0);
      wt(20);
      chk(req_pend == 3'b001, "R6 armed start pending", req_pend, 1);
      chk(scl_oe == 0 && sda_oe == 0, "R6 no drive without select", {scl_oe, sda_oe}, 0);
      chk(done_n == 0, "R6 no completion without select", done_n, 0);
      expect_bus("R6 no condition without select");

      out_sel = 1'b1;
      wait_done("R11 start completes");
      wt(3);
      chk(req_pend == 3'b000, "R11 start request cleared", req_pend, 0);
      chk(scl_oe == 1 && sda_oe == 1, "R8 start leaves both low", {scl_oe, sda_oe}, 3);
      exp_irq++; exp_busy = 1'b1;
      expect_bus("R8 generated start detected");

      pulse_req(1'b1, 1'b1, 1'b1);
      wait_done("R7 first served");
      wt(2);
      chk(req_pend == 3'b011, "R7 stop served first", req_pend, 3);
      exp_irq++; exp_busy = 1'b0;
      expect_bus("R9 generated stop detected");

      wait_done("R7 second served");
      wt(2);
      chk(req_pend == 3'b001, "R7 repeated start served second", req_pend, 1);
      exp_irq++; exp_busy = 1'b1;
      expect_bus("R10 generated repeated start detected");

      wait_done("R7 third served");
      wt(2);
      chk(req_pend == 3'b000, "R7 start served last", req_pend, 0);
      chk(scl_oe == 1 && sda_oe == 1, "R8 start from held bus", {scl_oe, sda_oe}, 3);
      expect_bus("R8 start from low bus gives no event");

      pulse_req(1'b0, 1'b0, 1'b1);
      wait_done("R11 stop completes");
      wt(2);
      chk(req_pend == 3'b000, "R11 stop request cleared", req_pend, 0);
      chk(scl_oe == 0 && sda_oe == 0, "R9 stop releases both", {scl_oe, sda_oe}, 0);
      exp_irq++; exp_busy = 1'b0;
      expect_bus("R9 generated stop detected");
      chk(done_n == 5, "R11 one pulse per condition", done_n, 5);

      out_sel = 1'b0;
      ser_sda = 1'b1; ser_scl = 1'b1;
      @(negedge clk);
      chk(scl_oe == 1 && sda_oe == 1, "R6 pins return to serial path", {scl_oe, sda_oe}, 3);
      ser_sda = 1'b0; ser_scl = 1'b0;
      @(negedge clk);
      wt(2);
      finish_run();
   end

endmodule